// File: doc/BRIEF.md
# Proxied Multi-Queue Message Manager

This block is a set of numbered hardware message queues that several processors share through one 32-bit register bus. A producer writes the words of a message into a per-queue window of data registers, and its write to the final register of that window commits the whole fixed-size message (sixteen 32-bit words) into the queue. A consumer reads the same window. Reads of the leading words only look at the oldest message; its read of the final register returns the last word and removes that message.

A separate status region gives one word per queue. The word carries the live count of pending messages and a sticky flag that records a commit lost to a full queue. Every queue also drives one level interrupt line, which stays high while the queue holds at least one message. The queue count and the depth of each queue are parameters. The default is 64 queues of depth 2, which is 128 messages in total.

Top module: `msgq_mgr`

## Requirements
- R1: Data registers sit at byte address 0x10000·p + 0x80·q + 4·i, where the queue field is address bits [15:7] and the register index i is bits [6:2]. The proxy field p (bits [19:16]) is ignored, so every proxy window reaches the same queue. Address bit 20 set selects the status region, where queue q's status word is at byte offset 4·q.
- R2: A write to register index 31 stores the last word and commits the staged message, however few words were written before it. Word k of a message is register index 16+k. Any word not written since the previous commit reads as zero.
- R3: A commit to a queue that already holds DEPTH messages is dropped. It sets bit 31 of that queue's status word, which stays set until reset, and the count stays at DEPTH.
- R4: A read of register index 31 returns word 15 of the oldest message and removes that message. Messages leave in the order they were committed.
- R5: Reads of register indices 16 to 30 return the matching word of the oldest message and change no state. Repeated reads return the same value.
- R6: The status word holds the pending-message count in bits [23:12]. All other bits except bit 31 read zero, and reading it has no side effect.
- R7: irq[q] is high exactly while queue q holds one or more messages. It rises in the cycle after the commit and falls in the cycle after the pop that empties the queue.
- R8: A read of register index 31 on an empty queue returns zero and leaves the count at zero.
- R9: Register indices 0 to 15, and queue numbers at or above NQ, read as zero. Writes to them are ignored.
- R10: After reset every count is zero, every overflow flag and interrupt is low, and every staging buffer is empty.
- R11: rd_data carries the result of a read in the clock cycle after rd_en was sampled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 21 | Byte address of the access |
| wr_en | input | 1 | Write strobe, one access per cycle |
| rd_en | input | 1 | Read strobe |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data, valid the cycle after rd_en |
| irq | output | NQ | Per-queue level interrupt, high while the queue is non-empty |

## Verification
The bench goes after five corner cases.
- Partial messages followed by a commit of word 31 only. A design that kept stale staging words would hand old data to the consumer instead of zeros.
- Over-filling a queue. An overflow bug either corrupts the oldest message through the spare slot or raises the count past DEPTH, and the status word or the popped data shows it.
- Popping an empty queue. A design that lets the count underflow raises its interrupt instead of leaving it low.
- Repeated reads of the leading words, alias writes through a non-zero proxy field, and accesses to low indices or queue numbers out of range. These catch a window that pops too early, decodes the wrong field, or accepts writes it should drop.
- The interrupt vector, compared against the model every cycle. This catches a line that lags or leads the count.

// File: rtl/msgq_pkg.sv
package msgq_pkg;
  localparam int DATA_W   = 32;
  localparam int ADDR_W   = 21;
  localparam int WORDS    = 16;
  localparam int WIDX_W   = 4;
  localparam int STAT_BIT = 20;
  localparam int QF_W     = 9;
  localparam int CNT_W    = 12;

  typedef struct packed {
    logic              stat;
    logic              q_ok;
    logic [QF_W-1:0]   q;
    logic              data;
    logic [WIDX_W-1:0] word;
    logic              last;
  } dec_t;

  typedef enum logic [1:0] {RK_ZERO, RK_STAT, RK_DATA} rkind_t;
endpackage

// File: rtl/msgq_dec.sv
module msgq_dec
  import msgq_pkg::*;
#(
  parameter int NQ = 64
) (
  input  logic [ADDR_W-1:0] addr,
  output dec_t              d
);
  logic unused_addr_bits;
  assign unused_addr_bits = ^{addr[1:0], addr[19:16]};

  always_comb begin
    d.stat = addr[STAT_BIT];
    d.q    = d.stat ? addr[10:2] : addr[15:7];
    d.q_ok = int'({23'd0, d.q}) < NQ;
    d.data = !addr[STAT_BIT] && addr[6];
    d.word = addr[5:2];
    d.last = d.data && (addr[5:2] == 4'hF);
  end
endmodule

// File: rtl/msgq_qctl.sv
module msgq_qctl
  import msgq_pkg::*;
#(
  parameter int DEPTH = 2,
  localparam int SLOTS = DEPTH + 1,
  localparam int SW = $clog2(SLOTS),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              stage_we,
  input  logic [WIDX_W-1:0] stage_word,
  input  logic              push,
  input  logic              pop,
  output logic [CW-1:0]     cnt,
  output logic              ovf,
  output logic              irq,
  output logic [SW-1:0]     head,
  output logic [SW-1:0]     tail,
  output logic [WORDS-1:0]  head_mask
);
  logic [WORDS-1:0] stage;
  logic [WORDS-1:0] slot_mask [SLOTS];
  logic             can_push, do_pop;
  logic [CW-1:0]    cnt_d;

  function automatic logic [SW-1:0] nxt(input logic [SW-1:0] p);
    return (p == SW'(SLOTS - 1)) ? '0 : p + 1'b1;
  endfunction

  assign can_push  = push && (int'(cnt) < DEPTH);
  assign do_pop    = pop && (cnt != '0);
  assign cnt_d     = cnt + CW'(can_push) - CW'(do_pop);
  assign head_mask = slot_mask[head];

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      ovf   <= 1'b0;
      irq   <= 1'b0;
      head  <= '0;
      tail  <= '0;
      stage <= '0;
      for (int s = 0; s < SLOTS; s++) slot_mask[s] <= '0;
    end else begin
      if (push) begin
        stage <= '0;
        if (can_push) begin
          slot_mask[tail] <= stage | 16'h8000;
          tail            <= nxt(tail);
        end else begin
          ovf <= 1'b1;
        end
      end else if (stage_we) begin
        stage[stage_word] <= 1'b1;
      end
      if (do_pop) head <= nxt(head);
      cnt <= cnt_d;
      irq <= (cnt_d != '0);
    end
  end

  assert_cnt_bound_R3: assert property (@(posedge clk) disable iff (rst)
    int'(cnt) <= DEPTH);
  assert_ovf_sticky_R3: assert property (@(posedge clk) disable iff (rst)
    (push && int'(cnt) == DEPTH) |=> ovf);
  assert_push_count_R2: assert property (@(posedge clk) disable iff (rst)
    (push && !pop && int'(cnt) < DEPTH) |=> (cnt == $past(cnt) + 1'b1));
  assert_pop_empty_R8: assert property (@(posedge clk) disable iff (rst)
    (pop && !push && cnt == '0) |=> (cnt == '0 && !irq));
  assert_irq_drop_R7: assert property (@(posedge clk) disable iff (rst)
    (pop && !push && cnt == CW'(1)) |=> !irq);
endmodule

// File: rtl/msgq_mgr.sv
module msgq_mgr
  import msgq_pkg::*;
#(
  parameter int NQ = 64,
  parameter int DEPTH = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [20:0]       addr,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [31:0]       wr_data,
  output logic [31:0]       rd_data,
  output logic [NQ-1:0]     irq
);
  localparam int SLOTS = DEPTH + 1;
  localparam int SW    = $clog2(SLOTS);
  localparam int CW    = $clog2(DEPTH + 1);
  localparam int QW    = $clog2(NQ);
  localparam int MEM_N = NQ * SLOTS * WORDS;
  localparam int MW    = $clog2(MEM_N);

  dec_t              d;
  logic [QW-1:0]     qi;
  logic [CW-1:0]     cnt_a  [NQ];
  logic [SW-1:0]     head_a [NQ];
  logic [SW-1:0]     tail_a [NQ];
  logic [WORDS-1:0]  mask_a [NQ];
  logic [NQ-1:0]     ovf_v;
  logic              mem_we, mem_re;
  logic [MW-1:0]     wa, ra;
  logic [DATA_W-1:0] mem [MEM_N];
  logic [DATA_W-1:0] mem_q, stat_q;
  logic              hit_q;
  rkind_t            kind_q;
  logic              unused_qhi;

  msgq_dec #(.NQ(NQ)) dec_i (.addr(addr), .d(d));

  assign qi         = d.q[QW-1:0];
  assign unused_qhi = ^d.q;
  assign mem_we     = wr_en && d.data && d.q_ok;
  assign mem_re     = rd_en && d.data && d.q_ok;
  assign wa = MW'((int'(qi) * SLOTS + int'(tail_a[qi])) * WORDS + int'(d.word));
  assign ra = MW'((int'(qi) * SLOTS + int'(head_a[qi])) * WORDS + int'(d.word));

  for (genvar g = 0; g < NQ; g++) begin : g_q
    logic sel;
    assign sel = d.q_ok && (qi == QW'(g));
    msgq_qctl #(.DEPTH(DEPTH)) qctl_i (
      .clk(clk), .rst(rst),
      .stage_we(mem_we && sel), .stage_word(d.word),
      .push(mem_we && sel && d.last), .pop(mem_re && sel && d.last),
      .cnt(cnt_a[g]), .ovf(ovf_v[g]), .irq(irq[g]),
      .head(head_a[g]), .tail(tail_a[g]), .head_mask(mask_a[g])
    );
  end

  always_ff @(posedge clk) begin
    if (mem_we) mem[wa] <= wr_data;
    if (mem_re) mem_q <= mem[ra];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      kind_q <= RK_ZERO;
      hit_q  <= 1'b0;
      stat_q <= '0;
    end else begin
      kind_q <= RK_ZERO;
      if (rd_en && d.q_ok && d.stat) begin
        kind_q <= RK_STAT;
        stat_q <= {ovf_v[qi], 7'd0, CNT_W'(cnt_a[qi]), 12'd0};
      end else if (mem_re) begin
        kind_q <= RK_DATA;
        hit_q  <= (cnt_a[qi] != '0) && mask_a[qi][d.word];
      end
    end
  end

  always_comb begin
    case (kind_q)
      RK_DATA: rd_data = hit_q ? mem_q : '0;
      RK_STAT: rd_data = stat_q;
      default: rd_data = '0;
    endcase
  end

  assert_bad_queue_zero_R9: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !d.q_ok) |=> (rd_data == '0));
  assert_low_index_zero_R9: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !d.stat && !d.data) |=> (rd_data == '0));
  assert_reset_quiet_R10: assert property (@(posedge clk)
    $past(rst) |-> (irq == '0 && rd_data == '0));
endmodule

// File: tb/msgq_mgr_tb_top.sv
`timescale 1ns/1ps
module msgq_mgr_tb_top;
  localparam int NQ = 4;
  localparam int DEPTH = 3;
  typedef logic [511:0] msg_t;

  logic clk = 1'b0, rst = 1'b1, wr_en = 1'b0, rd_en = 1'b0;
  logic [20:0] addr = '0;
  logic [31:0] wr_data = '0, rd_data;
  logic [NQ-1:0] irq;

  msg_t mq [NQ][$];
  msg_t stg [NQ];
  logic ovf [NQ];
  int n_chk = 0, n_fail = 0;
  bit running = 1'b0;

  always #2.5 clk = ~clk;

  msgq_mgr #(.NQ(NQ), .DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
    .wr_data(wr_data), .rd_data(rd_data), .irq(irq));

  function automatic logic [20:0] daddr(input int p, input int q, input int i);
    return 21'(p * 'h10000 + q * 'h80 + i * 4);
  endfunction
  function automatic logic [20:0] saddr(input int q);
    return 21'('h100000 + q * 4);
  endfunction

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (running) begin
      logic [NQ-1:0] e;
      for (int q = 0; q < NQ; q++) e[q] = (mq[q].size() != 0);
      check(32'(irq), 32'(e), "R7 irq vector");
    end
  end

  task automatic wr(input int p, input int q, input int i, input logic [31:0] v);
    @(negedge clk);
    addr = daddr(p, q, i); wr_data = v; wr_en = 1'b1;
    @(posedge clk);
    if (q < NQ && i >= 16) begin
      stg[q][(i-16)*32 +: 32] = v;
      if (i == 31) begin
        if (mq[q].size() < DEPTH) mq[q].push_back(stg[q]);
        else ovf[q] = 1'b1;
        stg[q] = '0;
      end
    end
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input int p, input int q, input int i, input string tag);
    logic [31:0] e;
    msg_t m;
    e = '0;
    if (q < NQ && i >= 16 && mq[q].size() != 0) begin
      m = mq[q][0];
      e = m[(i-16)*32 +: 32];
    end
    @(negedge clk);
    addr = daddr(p, q, i); rd_en = 1'b1;
    @(posedge clk);
    if (q < NQ && i == 31 && mq[q].size() != 0) void'(mq[q].pop_front());
    @(negedge clk);
    rd_en = 1'b0;
    check(rd_data, e, tag);
  endtask

  task automatic rds(input int q, input string tag);
    logic [31:0] e;
    e = '0;
    if (q < NQ) e = {ovf[q], 7'd0, 12'(mq[q].size()), 12'd0};
    @(negedge clk);
    addr = saddr(q); rd_en = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rd_en = 1'b0;
    check(rd_data, e, tag);
  endtask

  initial begin
    for (int q = 0; q < NQ; q++) begin stg[q] = '0; ovf[q] = 1'b0; end
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    check(32'(irq), 0, "R10 irq after reset");
    check(rd_data, 0, "R10 rd_data after reset");
    running = 1'b1;
    for (int q = 0; q < NQ; q++) rds(q, "R10 status after reset");

    // R2 R4 R6 R11: full message on queue 1
    for (int i = 16; i < 32; i++) wr(0, 1, i, 32'hA000_0000 + 32'(i));
    rds(1, "R6 count one");
    for (int i = 16; i < 31; i++) rd(0, 1, i, "R5 R11 head word");
    rd(0, 1, 20, "R5 repeat read");
    rds(1, "R5 count unchanged");
    rd(0, 1, 31, "R4 last word pops");
    rds(1, "R4 count zero");

    // R2 partial message, then commit-only message: staging cleared
    wr(0, 2, 16, 32'h1111_1111);
    wr(0, 2, 17, 32'h2222_2222);
    wr(0, 2, 31, 32'h3333_3333);
    wr(0, 2, 31, 32'h4444_4444);
    for (int i = 16; i < 20; i++) rd(0, 2, i, "R2 partial words");
    rd(0, 2, 31, "R2 pop first");
    for (int i = 16; i < 19; i++) rd(0, 2, i, "R2 staging cleared");
    rd(0, 2, 31, "R2 pop second");

    // R3 overflow and FIFO order R4
    for (int k = 0; k <= DEPTH; k++) begin
      wr(0, 0, 16, 32'h5000_0000 + 32'(k));
      wr(0, 0, 31, 32'h6000_0000 + 32'(k));
    end
    rds(0, "R3 overflow flag and count");
    for (int k = 0; k < DEPTH; k++) begin
      rd(0, 0, 16, "R4 fifo order word16");
      rd(0, 0, 31, "R4 fifo order word31");
    end
    rds(0, "R3 sticky after drain");

    // R8 pop on empty
    rd(0, 3, 31, "R8 empty pop returns zero");
    rds(3, "R8 count stays zero");

    // R9 low index and bad queue
    wr(0, 3, 3, 32'hDEAD_BEEF);
    rd(0, 3, 3, "R9 low index reads zero");
    wr(0, NQ, 31, 32'hBAD0_0001);
    rd(0, NQ, 31, "R9 bad queue reads zero");
    rds(NQ, "R9 bad status reads zero");
    rds(3, "R9 queue3 untouched");

    // R1 proxy alias
    wr(1, 3, 18, 32'hCAFE_0018);
    wr(2, 3, 31, 32'hCAFE_001F);
    rd(0, 3, 18, "R1 proxy alias word");
    rd(3, 3, 31, "R1 proxy alias pop");
    rds(3, "R1 empty after alias pop");

    running = 1'b0;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #400000;
    n_fail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule